// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single-channel DMA engine that walks a chain of descriptors kept in ordinary memory. Each descriptor occupies four consecutive 32-bit words: a byte count at offset 0, the source address at offset 4, the destination address at offset 8 and the address of the next descriptor at offset 12. Software loads a descriptor pointer, enables the channel, and the engine then fetches the descriptor, copies the data word by word in bursts, raises a one-cycle completion pulse and moves straight on to the descriptor named by the pointer. A chain whose last entry points back to its first gives continuous cyclic streaming, which is the usual way to feed a peripheral FIFO from a ring buffer or to drain one into it.

The source and destination addresses each have a 2-bit mode: increment, for the memory side, or hold, for a fixed peripheral data register. A burst reads up to 1, 2, 4 or 8 words into a small local buffer and then writes them out in order. One memory port with a fixed one-cycle read latency serves both descriptor fetches and data moves. The working byte count and both working addresses are visible as outputs at all times, so the position inside a buffer can be read while the channel runs.

The controller is one state machine with six named states. IDLE waits for a loaded pointer and an enabled channel (transition start: IDLE to FETCH). FETCH issues the four descriptor reads and captures the words (transition loaded: FETCH to PLAN, or empty: FETCH to DONE when the count is zero). PLAN is the burst boundary, where a cleared enable parks the channel and otherwise the burst length is fixed (transition go: PLAN to READ). READ issues the burst's source reads (transition filled: READ to WRITE). WRITE drains the buffer to the destination (transition more: WRITE to PLAN, or drained: WRITE to DONE). DONE emits the completion pulse and loads the next pointer (transition chain: DONE to FETCH). An abort from any state takes transition kill to IDLE.

Top module: `dma_chain_engine`

## Requirements
- R1: A descriptor fetch issues four reads at the pointer, pointer+4, pointer+8 and pointer+12, with the pointer's low four bits forced to zero; the words are taken as byte count, source, destination and next pointer, in that order.
- R2: A `fetch_req` pulse while the channel is idle latches `next_ptr`; when `fetch_req` and `en_set` are sampled at the same clock edge, the first descriptor read appears on the memory port after the second following edge and not before.
- R3: Address mode code 0 increments an address by 4 per word moved; codes 2 and 3 hold it; code 1 behaves as increment. Source and destination modes are independent.
- R4: A burst reads min(2^burst_sel, remaining words) source words, then writes the same words to the destination in order; no run of consecutive writes is longer than that burst length.
- R5: The byte count is limited to 65536; a larger value is treated as 65536 and the two low bits of the count are ignored, so the number of words moved equals the resulting count divided by 4.
- R6: `desc_done` is high for exactly one cycle when a descriptor's count reaches zero, `cur_count` is zero in that cycle, and in the next cycle the first read of the next descriptor is issued at its aligned pointer.
- R7: A chain whose last next pointer equals the first descriptor's address runs again from the first descriptor, restarting from the first descriptor's addresses.
- R8: An `en_clr` pulse parks the channel at the next burst boundary with no further memory traffic; `en_set` resumes it from the current addresses and count, so the data moved is identical to an uninterrupted run.
- R9: An `abort` pulse clears `chan_en`, and from the next cycle `active` is low and no memory request is issued until a new start.
- R10: `active` is high from the first descriptor fetch until an abort, including while parked; with `active` low, `mem_req` is low.
- R11: A descriptor with a zero byte count moves no data; on a self-referencing zero-count descriptor the completion pulses repeat every 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en_set | input | 1 | Pulse: set the channel enable |
| en_clr | input | 1 | Pulse: clear the channel enable (pause) |
| abort | input | 1 | Pulse: stop the channel and clear the enable |
| fetch_req | input | 1 | Pulse: latch `next_ptr` as the descriptor to load (idle only) |
| next_ptr | input | 32 | Descriptor pointer, low four bits ignored |
| burst_sel | input | 2 | Burst length code, 2^burst_sel words |
| src_mode | input | 2 | Source address mode: 0 increment, 2 hold |
| dst_mode | input | 2 | Destination address mode: 0 increment, 2 hold |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| chan_en | output | 1 | Current channel enable |
| active | output | 1 | Channel is running a chain |
| desc_done | output | 1 | One-cycle completion pulse per descriptor |
| cur_count | output | 17 | Working byte count remaining |
| cur_src | output | 32 | Working source address |
| cur_dst | output | 32 | Working destination address |

## Verification
The first descriptor read is due after the second rising edge following a sampled start, the next descriptor's first read in the cycle right after each completion pulse, the end of an abort at the very next cycle, and zero-count completions six cycles apart; the bench drives every input on a falling edge and samples on the following falling edges, counting edges exactly for these four cases. Data moves, whose length depends on burst size and count, are checked after the completion pulse by comparing memory contents, the working addresses and a write-run monitor against values computed from the descriptor. The sweep covers all four burst lengths against all four hold/increment combinations with a count that is neither a multiple of the burst nor of four.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_PLAN,
        S_READ,
        S_WRITE,
        S_DONE
    } chain_state_t;

    localparam logic [1:0] MODE_INC  = 2'd0;
    localparam logic [1:0] MODE_HOLD = 2'd2;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  logic [1:0]   mode,
    output logic [W-1:0] addr_next
);
    import dma_chain_pkg::*;

    logic hold;

    // codes 2 and 3 hold the address, 0 and 1 advance by one word
    assign hold      = (mode == MODE_HOLD) || (mode == 2'd3);
    assign addr_next = hold ? addr : addr + W'(4);
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    localparam int IW = $clog2(DEPTH);

    logic [W-1:0] slot [DEPTH];

    always_ff @(posedge clk) begin
        for (int s = 0; s < DEPTH; s++) begin
            if (wr_en && (wr_idx == IW'(s))) begin
                slot[s] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_idx];
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
    parameter int W         = 32,
    parameter int MAX_BYTES = 65536,
    parameter int MAX_BURST = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_set,
    input  logic                          en_clr,
    input  logic                          abort,
    input  logic                          fetch_req,
    input  logic [W-1:0]                  next_ptr,
    input  logic [1:0]                    burst_sel,
    input  logic [1:0]                    src_mode,
    input  logic [1:0]                    dst_mode,
    output logic                          mem_req,
    output logic                          mem_we,
    output logic [W-1:0]                  mem_addr,
    output logic [W-1:0]                  mem_wdata,
    input  logic [W-1:0]                  mem_rdata,
    output logic                          chan_en,
    output logic                          active,
    output logic                          desc_done,
    output logic [$clog2(MAX_BYTES):0]    cur_count,
    output logic [W-1:0]                  cur_src,
    output logic [W-1:0]                  cur_dst
);
    import dma_chain_pkg::*;

    localparam int CW   = $clog2(MAX_BYTES) + 1;
    localparam int WW   = CW - 2;
    localparam int IW   = $clog2(MAX_BURST);
    localparam int NW   = IW + 1;
    localparam logic [W-1:0] ALIGN_MASK = ~W'(15);

    chain_state_t state_q, state_nx;

    logic          chan_en_q, pend_q;
    logic [W-1:0]  ptr_q, nxt_q, src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic [2:0]    k_q;
    logic [NW-1:0] i_q, bn_q;

    logic [W-1:0]  src_nx, dst_nx, buf_rd;
    logic [7:0]    bw_wide;
    logic [NW-1:0] bw_c, nw_c;
    logic [WW-1:0] words_left;

    function automatic logic [CW-1:0] clamp_cnt(input logic [W-1:0] w);
        logic [W-1:0] t;
        t = (w > W'(MAX_BYTES)) ? W'(MAX_BYTES) : w;
        return {t[CW-1:2], 2'b00};
    endfunction

    // burst length: 2^burst_sel words, limited to the buffer depth
    assign bw_wide    = 8'd1 << burst_sel;
    assign bw_c       = (bw_wide > 8'(MAX_BURST)) ? NW'(MAX_BURST) : NW'(bw_wide);
    assign words_left = cnt_q[CW-1:2];
    assign nw_c       = (words_left < WW'(bw_c)) ? NW'(words_left) : bw_c;

    dma_addr_step #(.W(W)) u_src_step (
        .addr      (src_q),
        .mode      (src_mode),
        .addr_next (src_nx)
    );

    dma_addr_step #(.W(W)) u_dst_step (
        .addr      (dst_q),
        .mode      (dst_mode),
        .addr_next (dst_nx)
    );

    dma_burst_buf #(.W(W), .DEPTH(MAX_BURST)) u_buf (
        .clk     (clk),
        .wr_en   ((state_q == S_READ) && (i_q != '0)),
        .wr_idx  (IW'(i_q - NW'(1))),
        .wr_data (mem_rdata),
        .rd_idx  (i_q[IW-1:0]),
        .rd_data (buf_rd)
    );

    // next-state decision
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:  if (pend_q && chan_en_q) state_nx = S_FETCH;
            S_FETCH: if (k_q == 3'd4) state_nx = (cnt_q == '0) ? S_DONE : S_PLAN;
            S_PLAN:  if (chan_en_q) state_nx = S_READ;
            S_READ:  if (i_q == bn_q) state_nx = S_WRITE;
            S_WRITE: if (i_q == bn_q - NW'(1))
                         state_nx = (cnt_q == CW'(4)) ? S_DONE : S_PLAN;
            S_DONE:  state_nx = S_FETCH;
            default: state_nx = S_IDLE;
        endcase
        if (abort) state_nx = S_IDLE;
    end

    // state register and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            chan_en_q <= 1'b0;
            pend_q    <= 1'b0;
            ptr_q     <= '0;
            nxt_q     <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            cnt_q     <= '0;
            k_q       <= '0;
            i_q       <= '0;
            bn_q      <= '0;
        end else begin
            state_q <= state_nx;

            if (abort)       chan_en_q <= 1'b0;
            else if (en_set) chan_en_q <= 1'b1;
            else if (en_clr) chan_en_q <= 1'b0;

            if (abort) begin
                pend_q <= 1'b0;
            end else if (state_q == S_IDLE) begin
                if (state_nx == S_FETCH) pend_q <= 1'b0;
                if (fetch_req) begin
                    ptr_q  <= next_ptr & ALIGN_MASK;
                    pend_q <= 1'b1;
                end
            end

            k_q <= ((state_q == S_FETCH) && (k_q != 3'd4)) ? k_q + 3'd1 : 3'd0;

            unique case (state_q)
                S_FETCH: begin
                    unique case (k_q)
                        3'd1:    cnt_q <= clamp_cnt(mem_rdata);
                        3'd2:    src_q <= mem_rdata;
                        3'd3:    dst_q <= mem_rdata;
                        3'd4:    nxt_q <= mem_rdata;
                        default: ;
                    endcase
                end
                S_PLAN: begin
                    if (chan_en_q) begin
                        bn_q <= nw_c;
                        i_q  <= '0;
                    end
                end
                S_READ: begin
                    if (i_q < bn_q) src_q <= src_nx;
                    i_q <= (i_q == bn_q) ? '0 : i_q + NW'(1);
                end
                S_WRITE: begin
                    dst_q <= dst_nx;
                    cnt_q <= cnt_q - CW'(4);
                    i_q   <= (i_q == bn_q - NW'(1)) ? '0 : i_q + NW'(1);
                end
                S_DONE: begin
                    ptr_q <= nxt_q & ALIGN_MASK;
                end
                default: ;
            endcase
        end
    end

    // memory port and status outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            S_FETCH: begin
                mem_req  = (k_q < 3'd4);
                mem_addr = ptr_q + W'({k_q, 2'b00});
            end
            S_READ: begin
                mem_req  = (i_q < bn_q);
                mem_addr = src_q;
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = buf_rd;
            end
            default: ;
        endcase
    end

    assign chan_en   = chan_en_q;
    assign active    = (state_q != S_IDLE);
    assign desc_done = (state_q == S_DONE);
    assign cur_count = cnt_q;
    assign cur_src   = src_q;
    assign cur_dst   = dst_q;

    // R9: abort ends all activity at the next cycle
    a_r9_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!active && !chan_en && !mem_req));

    // R6: completion is followed at once by an aligned descriptor read
    a_r6_done_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_done && !abort) |=> (mem_req && !mem_we && (mem_addr[3:0] == 4'd0)));

    // R6: completion only with an exhausted count, and only one cycle long
    a_r6_done_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |-> (cur_count == '0));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        desc_done |=> !desc_done);

    // R5: working count never exceeds the limit and stays word-sized
    a_r5_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_count <= CW'(MAX_BYTES)) && (cur_count[1:0] == 2'b00));

    // R10: no memory traffic without an active chain
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req);
endmodule

// File: tb/dma_chain_engine_test.sv
module dma_chain_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_set = 0, en_clr = 0, abort = 0, fetch_req = 0;
    logic [31:0] next_ptr = '0;
    logic [1:0]  burst_sel = '0, src_mode = '0, dst_mode = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        chan_en, active, desc_done;
    logic [16:0] cur_count;
    logic [31:0] cur_src, cur_dst;

    logic [31:0] mem [1024];
    logic        tb_we = 0;
    logic [31:0] tb_a = '0, tb_d = '0;
    logic        stat_clr = 0;

    int checks = 0;
    int errs   = 0;
    int wr_cnt = 0, run_n = 0, maxrun = 0, log_n = 0;
    logic [31:0] rlog [4];

    always #10 clk = ~clk;

    dma_chain_engine uut (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .abort(abort), .fetch_req(fetch_req), .next_ptr(next_ptr),
        .burst_sel(burst_sel), .src_mode(src_mode), .dst_mode(dst_mode),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .chan_en(chan_en),
        .active(active), .desc_done(desc_done), .cur_count(cur_count),
        .cur_src(cur_src), .cur_dst(cur_dst)
    );

    // memory model: one-cycle read latency, bench preload port
    always @(posedge clk) begin
        if (tb_we) mem[tb_a[11:2]] <= tb_d;
        else if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
    end

    // traffic monitor
    always @(posedge clk) begin
        if (stat_clr) begin
            wr_cnt = 0; run_n = 0; maxrun = 0; log_n = 0;
        end else begin
            if (mem_req && mem_we) begin
                wr_cnt = wr_cnt + 1;
                run_n  = run_n + 1;
                if (run_n > maxrun) maxrun = run_n;
            end else begin
                run_n = 0;
            end
            if (mem_req && !mem_we && log_n < 4) begin
                rlog[log_n] = mem_addr;
                log_n = log_n + 1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errs + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        tb_we = 1; tb_a = a; tb_d = d;
        @(negedge clk);
        tb_we = 0;
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] c,
                            input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
        poke(at, c); poke(at + 4, s); poke(at + 8, d); poke(at + 12, n);
    endtask

    task automatic clear_stats();
        stat_clr = 1;
        @(negedge clk);
        stat_clr = 0;
    endtask

    // start with exact timing check of the first fetch (R2)
    task automatic start(input logic [31:0] p);
        fetch_req = 1; en_set = 1; next_ptr = p;
        @(negedge clk);
        fetch_req = 0; en_set = 0;
        chk(!active && !mem_req, "R2 no fetch one edge after start", {30'd0, active, mem_req}, 0);
        @(negedge clk);
        chk(mem_req && !mem_we && active && mem_addr == (p & ~32'hF),
            "R2 first descriptor read two edges after start", mem_addr, p & ~32'hF);
    endtask

    task automatic wait_done(input int lim, output bit got);
        got = 0;
        for (int n = 0; n < lim; n++) begin
            @(negedge clk);
            if (desc_done) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic do_abort();
        abort = 1;
        @(negedge clk);
        abort = 0;
    endtask

    initial begin
        bit got;
        int bw, expmax, bad, w1, gap;
        logic [31:0] sval, eval;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!active && !mem_req && !desc_done && !chan_en && cur_count == 0,
            "R10 reset state quiet", {27'd0, active, mem_req, desc_done, chan_en, 1'b0}, 0);

        // sweep: all burst lengths x all mode combinations, 22-byte count
        for (int bs = 0; bs < 4; bs++) begin
            for (int mc = 0; mc < 4; mc++) begin
                burst_sel = bs[1:0];
                src_mode  = mc[0] ? 2'd2 : 2'd0;
                dst_mode  = mc[1] ? 2'd2 : 2'd0;
                put_desc(32'h000, 32'd22, 32'h100, 32'h200, 32'h000);
                for (int j = 0; j < 5; j++) poke(32'h100 + 4 * j, 32'hA000_0000 + (bs * 4 + mc) * 16 + j);
                for (int j = 0; j < 5; j++) poke(32'h200 + 4 * j, 32'h0);
                poke(32'h214, 32'h5E5E_5E5E);
                clear_stats();
                start(32'h005);
                wait_done(200, got);
                chk(got, "R6 completion pulse seen", {31'd0, got}, 1);
                chk(cur_count == 0, "R6 count zero at completion", cur_count, 0);
                chk(active, "R10 active during chain", active, 1);
                chk(cur_src == (mc[0] ? 32'h100 : 32'h114), "R3 source address mode", cur_src,
                    mc[0] ? 32'h100 : 32'h114);
                chk(cur_dst == (mc[1] ? 32'h200 : 32'h214), "R3 destination address mode", cur_dst,
                    mc[1] ? 32'h200 : 32'h214);
                do_abort();
                chk(log_n == 4 && rlog[0] == 0 && rlog[1] == 4 && rlog[2] == 8 && rlog[3] == 12,
                    "R1 descriptor read addresses", rlog[3], 12);
                chk(wr_cnt == 5, "R5 low count bits ignored, words moved", wr_cnt, 5);
                bw = 1 << bs;
                expmax = (bw < 5) ? bw : 5;
                chk(maxrun == expmax, "R4 write run equals burst length", maxrun, expmax);
                bad = 0;
                if (!mc[1]) begin
                    for (int j = 0; j < 5; j++) begin
                        sval = 32'hA000_0000 + (bs * 4 + mc) * 16 + (mc[0] ? 0 : j);
                        if (mem[(32'h200 + 4 * j) >> 2] != sval) bad++;
                    end
                    if (mem[32'h214 >> 2] != 32'h5E5E_5E5E) bad++;
                end else begin
                    sval = 32'hA000_0000 + (bs * 4 + mc) * 16 + (mc[0] ? 0 : 4);
                    if (mem[32'h200 >> 2] != sval) bad++;
                    if (mem[32'h204 >> 2] != 32'h0) bad++;
                end
                chk(bad == 0, "R4 R3 destination contents", bad, 0);
            end
        end

        // R9: abort effect sampled after the sweep's last abort
        chk(!active && !chan_en && !mem_req, "R9 abort clears enable and activity",
            {29'd0, active, chan_en, mem_req}, 0);

        // two-entry ring
        burst_sel = 2'd1; src_mode = 2'd0; dst_mode = 2'd0;
        put_desc(32'h040, 32'd8,  32'h100, 32'h300, 32'h050);
        put_desc(32'h050, 32'd12, 32'h120, 32'h340, 32'h040);
        clear_stats();
        start(32'h040);
        wait_done(200, got);
        @(negedge clk);
        chk(!desc_done && mem_req && !mem_we && mem_addr == 32'h050,
            "R6 next descriptor read right after completion", mem_addr, 32'h050);
        wait_done(200, got);
        chk(got && cur_dst == 32'h34C, "R7 second descriptor finished", cur_dst, 32'h34C);
        @(negedge clk);
        chk(mem_req && mem_addr == 32'h040, "R7 ring wraps to first descriptor", mem_addr, 32'h040);
        wait_done(200, got);
        chk(got && cur_dst == 32'h308, "R7 first descriptor rerun from its addresses", cur_dst, 32'h308);
        do_abort();
        chk(!active && !chan_en && !mem_req, "R9 abort mid-ring stops at next cycle",
            {29'd0, active, chan_en, mem_req}, 0);
        repeat (5) @(negedge clk);
        chk(!mem_req && !active, "R9 no traffic after abort", {30'd0, mem_req, active}, 0);

        // zero-count self ring
        put_desc(32'h060, 32'd0, 32'h100, 32'h380, 32'h060);
        clear_stats();
        start(32'h060);
        wait_done(200, got);
        gap = 0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            gap++;
            if (desc_done) break;
        end
        chk(gap == 6, "R11 zero-count completion period", gap, 6);
        chk(wr_cnt == 0, "R11 zero-count moves no data", wr_cnt, 0);
        do_abort();

        // pause and resume
        burst_sel = 2'd0;
        put_desc(32'h070, 32'd64, 32'h100, 32'h400, 32'h070);
        for (int j = 0; j < 16; j++) poke(32'h100 + 4 * j, 32'hB000_0000 + j * 3);
        for (int j = 0; j < 16; j++) poke(32'h400 + 4 * j, 32'h0);
        clear_stats();
        start(32'h070);
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (wr_cnt >= 3) break;
        end
        en_clr = 1;
        @(negedge clk);
        en_clr = 0;
        repeat (10) @(negedge clk);
        w1 = wr_cnt;
        chk(w1 < 16, "R8 pause before completion", w1, 16);
        repeat (20) @(negedge clk);
        chk(wr_cnt == w1 && !mem_req, "R8 parked channel moves nothing", wr_cnt, w1);
        chk(active, "R10 active while parked", active, 1);
        en_set = 1;
        @(negedge clk);
        en_set = 0;
        wait_done(400, got);
        chk(got && wr_cnt == 16 && cur_dst == 32'h440, "R8 resume completes descriptor", wr_cnt, 16);
        bad = 0;
        for (int j = 0; j < 16; j++) begin
            eval = 32'hB000_0000 + j * 3;
            if (mem[(32'h400 + 4 * j) >> 2] != eval) bad++;
        end
        chk(bad == 0, "R8 data identical after pause", bad, 0);
        do_abort();

        // count clamp
        burst_sel = 2'd3; src_mode = 2'd0; dst_mode = 2'd2;
        put_desc(32'h080, 32'h0003_0002, 32'h400, 32'h800, 32'h080);
        clear_stats();
        start(32'h080);
        wait_done(80000, got);
        chk(got && wr_cnt == 16384, "R5 oversize count clamps to 64 KiB", wr_cnt, 16384);
        chk(cur_src == 32'h0001_0400, "R5 source advanced by 64 KiB", cur_src, 32'h0001_0400);
        chk(cur_dst == 32'h800, "R3 held destination unchanged", cur_dst, 32'h800);
        do_abort();

        $display("Simulation finished: %0d checks, %0d errors", checks, errs);
        $finish;
    end
endmodule